// File: doc/BRIEF.md
# Six-Channel Parameter Bank with Launch Trigger

This block is a byte-wide register bank on a local 8-bit offset bus. It keeps the settings for six independent channels: for each channel one control byte, a 16-bit page number and three more setting bytes. Every register can be read back. The channels are started from a single shared launch register, which takes a bitmask.

A write to the launch register starts every channel whose bit is set, and any number of channels can start from one write. Each started channel receives a one-cycle pulse and a registered copy of its settings, taken at that write. The copy holds the page number scaled to a 24-bit byte address. Bits of the mask above the channel count are reserved. Setting one of them raises an error flag and starts nothing. Whatever a channel does after its pulse happens outside this block.

Top module: `chan_launch_bank`

## Requirements
- R1: Channel n (0..5) has a first stripe at offsets 0x80+3n..0x82+3n: +0 is the control byte, +1 is the page low byte, +2 is the page high byte; each reads back the last value written.
- R2: Channel n has a second stripe at offsets 0x92+3n..0x94+3n holding three setting bytes S0, S1, S2 (in offset order); each reads back the last value written.
- R3: Writing one page byte leaves the other page byte of that channel unchanged.
- R4: The launch address for channel n is {page high, page low, 8'h00}, that is the page times 256, on launch_addr_o[24n+23:24n].
- R5: A write to offset 0xA5 with bit i set (i = 0..5) drives launch_o[i] high for exactly the one cycle after the write; several bits launch several channels together; without such a write launch_o is all zero.
- R6: launch_parm_o[32n+31:32n] = {S2, S1, S0, control byte} is captured at the launch write and held until that channel's next launch, whatever register writes follow.
- R7: Every launch write sets rsvd_err_o to 1 when bit 6 or bit 7 of the data is set and clears it to 0 otherwise; bits 6 and 7 launch no channel.
- R8: Reading offset 0xA5 returns the full last byte written to it, reserved bits included.
- R9: Reading any offset not named in R1, R2 or R8 returns 0x00, and a write to such an offset changes no register.
- R10: Reset clears all registers, captured copies, launch_o and rsvd_err_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for bus_addr/bus_wdata |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| launch_o | output | 6 | One-cycle launch pulse per channel |
| launch_addr_o | output | 144 | Captured 24-bit byte address per channel |
| launch_parm_o | output | 192 | Captured {S2,S1,S0,control} per channel |
| rsvd_err_o | output | 1 | Reserved mask bits seen on last launch write |

## Verification
Each of the 36 channel bytes gets a value that is a distinct function of its channel and byte index. A misplaced stripe, a swapped page half or a crossed channel then shows up as a wrong readback. The launch register is swept over all 256 byte values, and after every write the six pulses, the error flag and all six captured copies are compared with a model. This sweep tells apart single launches, multi-channel launches, reserved-only writes and mixed writes, and it shows whether channels that were not launched kept their old copies. A second value pattern, followed by a readback of all 256 offsets, covers the hold behaviour of the copies and the undecoded space.

// File: rtl/clb_pkg.sv
package clb_pkg;
  localparam int CLB_NCH   = 6;
  localparam int CLB_DW    = 8;
  localparam int CLB_AW    = 8;
  localparam int CLB_GRP   = 3;
  localparam int CLB_A_OFS = 'h80;
  localparam int CLB_B_OFS = 'h92;
  localparam int CLB_T_OFS = 'hA5;
endpackage

// File: rtl/clb_chan.sv
module clb_chan #(
  parameter int DW  = 8,
  parameter int GRP = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2*GRP-1:0]           wr_sel,
  input  logic [DW-1:0]              wdata,
  input  logic                       fire,
  output logic [2*GRP-1:0][DW-1:0]   regs_o,
  output logic                       pulse_o,
  output logic [3*DW-1:0]            snap_addr_o,
  output logic [4*DW-1:0]            snap_parm_o
);
  localparam int NB = 2*GRP;

  logic [NB-1:0][DW-1:0] reg_q, reg_d;
  logic [3*DW-1:0]       addr_q, addr_d;
  logic [4*DW-1:0]       parm_q, parm_d;
  logic                  pulse_q;

  always_comb begin
    reg_d = reg_q;
    for (int k = 0; k < NB; k++) begin
      if (wr_sel[k]) reg_d[k] = wdata;
    end
  end

  always_comb begin
    addr_d = {reg_q[2], reg_q[1], {DW{1'b0}}};
    parm_d = {reg_q[GRP+2], reg_q[GRP+1], reg_q[GRP], reg_q[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q   <= '0;
      addr_q  <= '0;
      parm_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      reg_q   <= reg_d;
      pulse_q <= fire;
      if (fire) begin
        addr_q <= addr_d;
        parm_q <= parm_d;
      end
    end
  end

  assign regs_o      = reg_q;
  assign pulse_o     = pulse_q;
  assign snap_addr_o = addr_q;
  assign snap_parm_o = parm_q;

  // R3: writing the low page byte keeps the high page byte
  p_page_hi_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[1] && !wr_sel[2]) |=> $stable(reg_q[2]));
  // R3: writing the high page byte keeps the low page byte
  p_page_lo_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[2] && !wr_sel[1]) |=> $stable(reg_q[1]));
  // R6: captured settings hold while the channel is not launched
  p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(parm_q));
endmodule

// File: rtl/clb_trig.sv
module clb_trig #(
  parameter int DW  = 8,
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [DW-1:0]  wdata,
  output logic [NCH-1:0] fire_o,
  output logic [DW-1:0]  mask_o,
  output logic           err_o
);
  logic [DW-1:0] mask_q, mask_d;
  logic          err_q, err_d;

  always_comb begin
    mask_d = mask_q;
    err_d  = err_q;
    if (wr) begin
      mask_d = wdata;
      err_d  = |wdata[DW-1:NCH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      err_q  <= err_d;
    end
  end

  assign fire_o = wr ? wdata[NCH-1:0] : '0;
  assign mask_o = mask_q;
  assign err_o  = err_q;

  // R7: reserved bits on a launch write raise the flag
  p_rsvd_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (|wdata[DW-1:NCH])) |=> err_o);
  // R7: flag is held between launch writes
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(err_o));
endmodule

// File: rtl/chan_launch_bank.sv
module chan_launch_bank
  import clb_pkg::*;
#(
  parameter int NCH = CLB_NCH,
  parameter int DW  = CLB_DW,
  parameter int AW  = CLB_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    launch_o,
  output logic [NCH*3*DW-1:0] launch_addr_o,
  output logic [NCH*4*DW-1:0] launch_parm_o,
  output logic              rsvd_err_o
);
  localparam int NB = 2*CLB_GRP;
  localparam logic [AW-1:0] T_ADDR = AW'(CLB_T_OFS);

  logic [NCH-1:0][NB-1:0][DW-1:0] chan_regs;
  logic [NCH-1:0]                 fire;
  logic [DW-1:0]                  mask_q;
  logic                           trig_wr;

  assign trig_wr = bus_wr && (bus_addr == T_ADDR);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [NB-1:0] sel;
    for (genvar k = 0; k < CLB_GRP; k++) begin : g_byte
      assign sel[k] = bus_wr &&
        (bus_addr == AW'(CLB_A_OFS + CLB_GRP*n + k));
      assign sel[CLB_GRP+k] = bus_wr &&
        (bus_addr == AW'(CLB_B_OFS + CLB_GRP*n + k));
    end
    clb_chan #(.DW(DW), .GRP(CLB_GRP)) chan_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_sel     (sel),
      .wdata      (bus_wdata),
      .fire       (fire[n]),
      .regs_o     (chan_regs[n]),
      .pulse_o    (launch_o[n]),
      .snap_addr_o(launch_addr_o[n*3*DW +: 3*DW]),
      .snap_parm_o(launch_parm_o[n*4*DW +: 4*DW])
    );
  end

  clb_trig #(.DW(DW), .NCH(NCH)) trig_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (trig_wr),
    .wdata (bus_wdata),
    .fire_o(fire),
    .mask_o(mask_q),
    .err_o (rsvd_err_o)
  );

  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NCH; n++) begin
      for (int k = 0; k < CLB_GRP; k++) begin
        if (bus_addr == AW'(CLB_A_OFS + CLB_GRP*n + k)) bus_rdata = chan_regs[n][k];
        if (bus_addr == AW'(CLB_B_OFS + CLB_GRP*n + k)) bus_rdata = chan_regs[n][CLB_GRP+k];
      end
    end
    if (bus_addr == T_ADDR) bus_rdata = mask_q;
  end

  // R5: no launch pulse without a launch write the cycle before
  p_no_stray_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_wr |=> (launch_o == '0));
  // R5: a launch write pulses exactly the channels in the mask
  p_launch_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> (launch_o == $past(bus_wdata[NCH-1:0])));
endmodule

// File: tb/chan_launch_bank_tb.sv
`timescale 1ns/1ps
module chan_launch_bank_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic [5:0]   launch_o;
  logic [143:0] launch_addr_o;
  logic [191:0] launch_parm_o;
  logic         rsvd_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  m_reg [6][6];
  logic [23:0] m_addr [6];
  logic [31:0] m_parm [6];
  logic [7:0]  m_mask;

  always #10 clk = ~clk;

  chan_launch_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .launch_o(launch_o),
    .launch_addr_o(launch_addr_o), .launch_parm_o(launch_parm_o),
    .rsvd_err_o(rsvd_err_o)
  );

  task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_ofs(input int n, input int b);
    return (b < 3) ? 8'(8'h80 + 3*n + b) : 8'(8'h92 + 3*n + b - 3);
  endfunction

  function automatic bit mapped(input int a);
    if (a == 'hA5) return 1;
    if (a >= 'h80 && a <= 'h91) return 1;
    if (a >= 'h92 && a <= 'hA3) return 1;
    return 0;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(req, {184'd0, bus_rdata}, {184'd0, exp});
  endtask

  task automatic chk_snaps(input string req);
    for (int n = 0; n < 6; n++) begin
      chk(req, {168'd0, launch_addr_o[n*24 +: 24]}, {168'd0, m_addr[n]});
      chk(req, {160'd0, launch_parm_o[n*32 +: 32]}, {160'd0, m_parm[n]});
    end
  endtask

  task automatic fill(input int seed);
    for (int n = 0; n < 6; n++) begin
      for (int b = 0; b < 6; b++) begin
        m_reg[n][b] = 8'((n*41 + b*13 + seed) ^ (seed >> 2));
        wr(reg_ofs(n, b), m_reg[n][b]);
      end
    end
  endtask

  task automatic read_all(input string req);
    @(negedge clk);
    for (int n = 0; n < 6; n++)
      for (int b = 0; b < 6; b++)
        rd_chk(req, reg_ofs(n, b), m_reg[n][b]);
  endtask

  task automatic launch(input logic [7:0] m);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'hA5; bus_wdata = m;
    @(negedge clk);
    bus_wr = 1'b0;
    m_mask = m;
    for (int n = 0; n < 6; n++) begin
      if (m[n]) begin
        m_addr[n] = {m_reg[n][2], m_reg[n][1], 8'h00};
        m_parm[n] = {m_reg[n][5], m_reg[n][4], m_reg[n][3], m_reg[n][0]};
      end
    end
    chk("R5 pulse", {186'd0, launch_o}, {186'd0, m[5:0]});
    chk("R7 flag", {191'd0, rsvd_err_o}, {191'd0, (m[7] | m[6])});
    chk_snaps("R4/R6 snapshot");
    rd_chk("R8 readback", 8'hA5, m);
    @(negedge clk);
    chk("R5 one cycle", {186'd0, launch_o}, 192'd0);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 6; n++) begin
      m_addr[n] = '0; m_parm[n] = '0;
      for (int b = 0; b < 6; b++) m_reg[n][b] = '0;
    end
    m_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 launch", {186'd0, launch_o}, 192'd0);
    chk("R10 flag", {191'd0, rsvd_err_o}, 192'd0);
    chk_snaps("R10 snapshot");
    read_all("R10 regs");
    rd_chk("R10 trig", 8'hA5, 8'h00);

    // R1, R2: distinct pattern per channel and byte
    fill(5);
    read_all("R1/R2 readback");

    // R3: replace only one page half
    m_reg[2][1] = 8'hC4; wr(reg_ofs(2, 1), 8'hC4);
    m_reg[4][2] = 8'h3B; wr(reg_ofs(4, 2), 8'h3B);
    read_all("R3 half write");

    // R4..R8: sweep every launch byte
    for (int m = 0; m < 256; m++) launch(8'(m));

    // R6: later writes leave held copies alone
    fill(77);
    @(negedge clk);
    chk_snaps("R6 hold");
    launch(8'h3F);
    launch(8'h00);

    // R9: undecoded space
    wr(8'hA4, 8'hFF); wr(8'h7F, 8'hFF); wr(8'hA6, 8'hFF); wr(8'h00, 8'hFF);
    read_all("R9 no side effect");
    for (int a = 0; a < 256; a++)
      if (!mapped(a)) rd_chk("R9 unmapped read", 8'(a), 8'h00);
    rd_chk("R8 final", 8'hA5, m_mask);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule